// File: doc/BRIEF.md
# Adaptive Bit-Weight Reconstruction for a SAR Channel

This block turns the raw decision vector of one successive-approximation channel into a signed output sample. Each decision bit is read as +1 (bit set) or −1 (bit clear) and scaled by its own digital weight. The signed terms are added to a digital offset term, rounded to integer output units and clamped to the output range. The nominal weights scale by about 1.85 from one bit to the next. This redundancy lets capacitor mismatch be corrected digitally instead of being fixed by trimming.

When a sample is marked for calibration, the block also receives a reference value for that sample. It then moves every weight and the offset one sign-data least-mean-square step toward that reference. Normal conversion continues without interruption, so the correction of gain, offset and static nonlinearity runs in the background. All weights and the offset are exposed on output ports so they can be observed.

Top module: `sar_bit_recon`

## Requirements
- R1: With weights w_i (signed, WFRAC=6 fractional bits) and offset c in the same format, the output is clamp(floor((Σ s_i·w_i + c + 2^(WFRAC−1)) / 2^WFRAC)). Here s_i = +1 when in_bits[i] is 1 and −1 when it is 0, and bit 0 is the smallest weight.
- R2: After a synchronous reset, out_valid is 0 and the offset is 0. Weight i equals n_i, where n_0 = 2^(WFRAC−1) and n_i = floor((185·n_{i−1} + 50) / 100), giving 32, 59, 109, 202, 374, 692 for six bits.
- R3: The output saturates to [−2^(OUTW−1), 2^(OUTW−1)−1] and never wraps.
- R4: out_valid rises exactly one clock after an accepted in_valid and is 0 otherwise. out_data keeps its last value while no sample arrives.
- R5: On a calibration sample, e = out − in_ref, where out is the clamped output of R1 and in_ref is a signed REFW-bit value. The step is d = floor(e·2^WFRAC / 2^MU_SH). Each weight becomes w_i − s_i·d and the offset becomes c − d.
- R6: Weights and offset change only on cycles where in_valid and in_cal are both 1. In all other cases in_ref and in_cal have no effect.
- R7: A calibration sample's own output is computed with the weights held before that sample's update. The update takes effect from the next sample.
- R8: Each weight and the offset saturate to the signed WW-bit range (WW=16: −32768..32767) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw decision vector is present this cycle |
| in_bits | input | NBITS | Raw decisions, bit 0 is the smallest weight |
| in_cal | input | 1 | Sample takes part in adaptation |
| in_ref | input | REFW | Signed reference value for a calibration sample |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | OUTW | Signed corrected sample |
| out_weights | output | NBITS*WW | Current weights, weight i in bits [i*WW +: WW] |
| out_offset | output | WW | Current signed offset term |

## Verification
Two things can happen in the same clock edge: a sample's output is produced, and the update triggered by that same sample changes the weights. The bench sends back-to-back calibration samples so that each output depends on the weights left by the previous update. Each output is compared with a bench model that is evaluated before its own update is applied. The exposed weights are then compared with the model after that update. Reference values far outside the output range keep the error sign fixed. This drives output saturation and weight saturation at the same time.

// File: rtl/sar_recon_pkg.sv
package sar_recon_pkg;

  // Nominal weight of bit idx in fixed point: half an output unit for the
  // smallest bit, each next bit about 1.85 times larger, rounded.
  function automatic int nominal_weight(input int idx, input int frac);
    int w;
    w = 1 << (frac - 1);
    for (int k = 0; k < idx; k++) begin
      w = (w * 185 + 50) / 100;
    end
    return w;
  endfunction

endpackage

// File: rtl/sar_wsum.sv
module sar_wsum #(
  parameter int NBITS = 6,
  parameter int WW    = 16,
  parameter int WFRAC = 6,
  parameter int OUTW  = 6,
  localparam int ACCW = WW + $clog2(NBITS + 1) + 1
) (
  input  logic [NBITS-1:0]         bits,
  input  logic [NBITS*WW-1:0]      weights_flat,
  input  logic signed [WW-1:0]     offset,
  output logic signed [ACCW-1:0]   acc_round,
  output logic signed [OUTW-1:0]   out_sat
);

  localparam logic signed [ACCW-1:0] HALF_A = ACCW'(1 << (WFRAC - 1));
  localparam logic signed [ACCW-1:0] OMAX_A = {{(ACCW-OUTW+1){1'b0}}, {(OUTW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] OMIN_A = {{(ACCW-OUTW+1){1'b1}}, {(OUTW-1){1'b0}}};

  logic signed [ACCW-1:0] acc;

  always_comb begin
    logic signed [WW-1:0]   wi;
    logic signed [ACCW-1:0] wi_ext;
    acc = {{(ACCW-WW){offset[WW-1]}}, offset};
    for (int i = 0; i < NBITS; i++) begin
      wi     = weights_flat[i*WW +: WW];
      wi_ext = {{(ACCW-WW){wi[WW-1]}}, wi};
      acc    = bits[i] ? acc + wi_ext : acc - wi_ext;
    end
    acc_round = (acc + HALF_A) >>> WFRAC;
    if (acc_round > OMAX_A)      out_sat = {1'b0, {(OUTW-1){1'b1}}};
    else if (acc_round < OMIN_A) out_sat = {1'b1, {(OUTW-1){1'b0}}};
    else                         out_sat = acc_round[OUTW-1:0];
  end

endmodule

// File: rtl/sar_lms_bank.sv
module sar_lms_bank #(
  parameter int NBITS = 6,
  parameter int WW    = 16,
  parameter int WFRAC = 6,
  parameter int ERRW  = 9,
  parameter int MU_SH = 3,
  localparam int DW   = ERRW + WFRAC,
  localparam int UW   = WW + DW + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   upd_en,
  input  logic [NBITS-1:0]       bits,
  input  logic signed [ERRW-1:0] err,
  output logic [NBITS*WW-1:0]    weights_flat,
  output logic signed [WW-1:0]   offset
);

  localparam logic signed [UW-1:0] WMAX_U = {{(UW-WW+1){1'b0}}, {(WW-1){1'b1}}};
  localparam logic signed [UW-1:0] WMIN_U = {{(UW-WW+1){1'b1}}, {(WW-1){1'b0}}};

  logic signed [DW-1:0] err_w;
  logic signed [DW-1:0] delta;

  always_comb begin
    err_w = {{WFRAC{err[ERRW-1]}}, err};
    delta = (err_w <<< WFRAC) >>> MU_SH;
  end

  function automatic logic signed [WW-1:0] sat_step(
    input logic signed [WW-1:0] cur,
    input logic signed [DW-1:0] d,
    input logic                 sub
  );
    logic signed [UW-1:0] a;
    logic signed [UW-1:0] b;
    logic signed [UW-1:0] s;
    a = {{(UW-WW){cur[WW-1]}}, cur};
    b = {{(UW-DW){d[DW-1]}}, d};
    s = sub ? a - b : a + b;
    if (s > WMAX_U)      return {1'b0, {(WW-1){1'b1}}};
    else if (s < WMIN_U) return {1'b1, {(WW-1){1'b0}}};
    else                 return s[WW-1:0];
  endfunction

  for (genvar i = 0; i < NBITS; i++) begin : g_w
    localparam logic signed [WW-1:0] W_NOM =
      WW'(sar_recon_pkg::nominal_weight(i, WFRAC));
    logic signed [WW-1:0] w_q;
    always_ff @(posedge clk) begin
      if (rst)         w_q <= W_NOM;
      else if (upd_en) w_q <= sat_step(w_q, delta, bits[i]);
    end
    assign weights_flat[i*WW +: WW] = w_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         offset <= '0;
    else if (upd_en) offset <= sat_step(offset, delta, 1'b1);
  end

  // R5: a positive error never raises the offset
  p_offset_dir_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_en) && ($past(err) > 0)) |->
      (offset <= $past(offset)));

  // R6: no update without a calibration sample
  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd_en)) |->
      ($stable(weights_flat) && $stable(offset)));

endmodule

// File: rtl/sar_bit_recon.sv
module sar_bit_recon #(
  parameter int NBITS = 6,
  parameter int WW    = 16,
  parameter int WFRAC = 6,
  parameter int OUTW  = 6,
  parameter int REFW  = 8,
  parameter int MU_SH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [NBITS-1:0]         in_bits,
  input  logic                     in_cal,
  input  logic signed [REFW-1:0]   in_ref,
  output logic                     out_valid,
  output logic signed [OUTW-1:0]   out_data,
  output logic [NBITS*WW-1:0]      out_weights,
  output logic signed [WW-1:0]     out_offset
);

  localparam int ERRW = REFW + 1;
  localparam int ACCW = WW + $clog2(NBITS + 1) + 1;
  localparam logic signed [ACCW-1:0] OMAX_A = {{(ACCW-OUTW+1){1'b0}}, {(OUTW-1){1'b1}}};

  logic signed [ACCW-1:0] acc_round;
  logic signed [OUTW-1:0] out_sat;
  logic signed [ERRW-1:0] err;
  logic                   upd_en;

  sar_wsum #(
    .NBITS(NBITS), .WW(WW), .WFRAC(WFRAC), .OUTW(OUTW)
  ) u_sum (
    .bits         (in_bits),
    .weights_flat (out_weights),
    .offset       (out_offset),
    .acc_round    (acc_round),
    .out_sat      (out_sat)
  );

  assign err    = {{(ERRW-OUTW){out_sat[OUTW-1]}}, out_sat} - {in_ref[REFW-1], in_ref};
  assign upd_en = in_valid & in_cal;

  sar_lms_bank #(
    .NBITS(NBITS), .WW(WW), .WFRAC(WFRAC), .ERRW(ERRW), .MU_SH(MU_SH)
  ) u_bank (
    .clk          (clk),
    .rst          (rst),
    .upd_en       (upd_en),
    .bits         (in_bits),
    .err          (err),
    .weights_flat (out_weights),
    .offset       (out_offset)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= out_sat;
    end
  end

  // R2: clean state right after reset
  p_reset_state_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && (out_offset == '0)));

  // R4: one-cycle latency of the valid strobe
  p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R4: output held while idle
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_data));

  // R3: an overlarge sum lands on the upper bound
  p_sat_high_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(acc_round) > OMAX_A)) |->
      (out_data == {1'b0, {(OUTW-1){1'b1}}}));

endmodule

// File: tb/sar_bit_recon_tb.sv
`timescale 1ns/1ps
module sar_bit_recon_tb;

  localparam int NB = 6;
  localparam int WW = 16;
  localparam int WF = 6;
  localparam int OW = 6;
  localparam int RW = 8;
  localparam int MS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NB-1:0] in_bits = '0;
  logic in_cal = 1'b0;
  logic signed [RW-1:0] in_ref = '0;
  logic out_valid;
  logic signed [OW-1:0] out_data;
  logic [NB*WW-1:0] out_weights;
  logic signed [WW-1:0] out_offset;

  int checks = 0;
  int fails = 0;
  int wm[NB];
  int om;
  int last_out;

  always #2.5 clk = ~clk;

  sar_bit_recon #(.NBITS(NB), .WW(WW), .WFRAC(WF), .OUTW(OW), .REFW(RW), .MU_SH(MS))
  u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits), .in_cal(in_cal),
    .in_ref(in_ref), .out_valid(out_valid), .out_data(out_data),
    .out_weights(out_weights), .out_offset(out_offset)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int predict(input logic [NB-1:0] b);
    int acc;
    acc = om;
    for (int i = 0; i < NB; i++) acc += b[i] ? wm[i] : -wm[i];
    acc = (acc + (1 << (WF - 1))) >>> WF;
    return clampi(acc, -(1 << (OW - 1)), (1 << (OW - 1)) - 1);
  endfunction

  task automatic model_reset();
    int w;
    w = 1 << (WF - 1);
    for (int i = 0; i < NB; i++) begin
      wm[i] = w;
      w = (w * 185 + 50) / 100;
    end
    om = 0;
  endtask

  task automatic check_weights(input string tag);
    for (int i = 0; i < NB; i++) begin
      int a;
      a = int'($signed(out_weights[i*WW +: WW]));
      chk(a == wm[i], tag, a, wm[i]);
    end
    chk(int'(out_offset) == om, tag, int'(out_offset), om);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_cal = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    last_out = 0;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
    check_weights("R2");
  endtask

  task automatic sample(input logic [NB-1:0] code, input bit cal, input int refv,
                        input string otag, input string wtag);
    int e, err, d;
    @(negedge clk);
    in_valid = 1'b1; in_bits = code; in_cal = cal; in_ref = refv[RW-1:0];
    e = predict(code);
    @(posedge clk); #1;
    chk(out_valid == 1'b1, "R4", int'(out_valid), 1);
    chk(int'(out_data) == e, otag, int'(out_data), e);
    last_out = e;
    if (cal) begin
      err = e - refv;
      d = (err <<< WF) >>> MS;
      for (int i = 0; i < NB; i++)
        wm[i] = clampi(code[i] ? wm[i] - d : wm[i] + d, -32768, 32767);
      om = clampi(om - d, -32768, 32767);
    end
    check_weights(wtag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_cal = 1'b1; in_ref = 8'sd99;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      chk(out_valid == 1'b0, "R4", int'(out_valid), 0);
      chk(int'(out_data) == last_out, "R4", int'(out_data), last_out);
    end
    check_weights("R6");
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    // R1 exhaustive sweep, R6 ref/cal ignored without calibration
    for (int c = 0; c < (1 << NB); c++)
      sample(c[NB-1:0], 1'b0, (c * 29) % 200 - 100, "R1", "R6");
    idle(3);

    // R5 / R7 back-to-back calibration toward a binary target, with gaps
    for (int k = 0; k < 300; k++) begin
      int c;
      c = (k * 37 + 5) % (1 << NB);
      sample(c[NB-1:0], 1'b1, c - 32, "R7", "R5");
      if (k % 23 == 22) idle(2);
    end
    // frozen weights reused for normal samples
    for (int c = 0; c < (1 << NB); c += 5)
      sample(c[NB-1:0], 1'b0, 0, "R1", "R6");

    // R3 high saturation and R8 weight saturation
    do_reset();
    for (int k = 0; k < 60; k++)
      sample({NB{1'b1}}, 1'b1, 127, "R3", "R8");
    chk(int'(out_data) == 31, "R3", int'(out_data), 31);
    chk(int'(out_offset) == 32767, "R8", int'(out_offset), 32767);

    // R3 low saturation and R8 lower clamp
    do_reset();
    for (int k = 0; k < 60; k++)
      sample({NB{1'b0}}, 1'b1, -128, "R3", "R8");
    chk(int'(out_data) == -32, "R3", int'(out_data), -32);
    chk(int'(out_offset) == -32768, "R8", int'(out_offset), -32768);
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule